// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Distributed Refresh

This block sits between a processor-side request port and a DRAM whose address pins are shared between row and column. A host offers one read or write per handshake (valid/ready). The controller latches the request, places the upper address bits on the shared bus with the row strobe, then the lower bits with the column strobe. It steers the active-low write enable and output enable and returns read data with a one-cycle valid pulse. All four DRAM strobes are active low.

A free-running timer requests one refresh per interval. The interval is the retention period divided by the clock period times the number of rows, so each row is refreshed once per retention period, spread evenly in time. A refresh is a row-strobe-only cycle that drives the refresh row counter onto the bus. Refresh wins over a waiting host request. The request is held off with ready low until the refresh and its precharge have finished. Two status outputs report that the controller is occupied and that a refresh is in progress.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, ras_n, cas_n, we_n and oe_n are 1, dq_oe, busy, refreshing and rsp_valid are 0, and req_ready is 1.
- R2: On an accepted request the row (address bits [ROW_W+COL_W-1:COL_W]) is on the address bus in the cycle after the accepting edge, with ras_n low. Exactly T_RCD cycles later cas_n falls with the column (bits [COL_W-1:0]) on the bus. The row is held in a register and does not change while ras_n is low.
- R3: cas_n is low only while ras_n is low. It stays low for CAS_LAT cycles, and then ras_n and cas_n rise together. ras_n then stays high for at least T_PRE cycles before it falls again.
- R4: While cas_n is low in a write, we_n=0, oe_n=1, dq_oe=1 and dq_out carries the write word. In a read, we_n=1, oe_n=0 and dq_oe=0. we_n and oe_n are never low together.
- R5: A read raises rsp_valid for exactly one cycle, T_RCD+CAS_LAT clock edges after the accepting edge, carrying the word on dq_in in the last cycle of cas_n low. A write produces no rsp_valid.
- R6: Refresh requests are spaced RETAIN_NS / (CLK_NS * 2^ROW_W) cycles apart, rounded down. Each refresh starts no more than one access length away from its slot.
- R7: A refresh holds ras_n low for T_REF cycles with cas_n, we_n and oe_n high. It drives the refresh row counter on the bus; the counter starts at 0, advances by one per refresh and wraps after 2^ROW_W-1.
- R8: While a refresh is pending or running, req_ready is 0. A request presented then is accepted only after the refresh and its T_PRE precharge, and it then completes correctly.
- R9: busy is 1 whenever an access or refresh (including its precharge) is in progress and 0 when req_ready is 1. refreshing is 1 exactly during the RAS-only refresh.
- R10: Every address written through the port and later read back returns the last word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller takes the request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Returned read word |
| busy | output | 1 | Access or refresh in progress |
| refreshing | output | 1 | RAS-only refresh in progress |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from DRAM |

## Verification
The whole 256-word space is written with an odd-multiplier pattern and read back. It is then rewritten in descending order with an XOR pattern and read again. This tells a swapped or truncated row/column split from a correct one, and stale data from fresh data. Across these sweeps a strobe monitor times every RAS, CAS and precharge window against the parameters. It separates host accesses from refreshes by whether a request was just accepted. Running for many refresh intervals also shows the refresh row counter wrapping and the interval spacing. A request offered in the middle of a refresh shows it is held back and then served intact.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_REF
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        return max2(max2(a, b), max2(c, d));
    endfunction

    // cycles between refresh slots: retention / (clock period * rows), at least 1
    function automatic int refresh_interval(input int retain_ns, input int clk_ns, input int rows);
        int iv;
        iv = retain_ns / (clk_ns * rows);
        return (iv < 1) ? 1 : iv;
    endfunction

endpackage

// File: rtl/mdc_refresh_timer.sv
module mdc_refresh_timer #(
    parameter int INTERVAL = 100,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int IV_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [IV_W-1:0] cnt;
    logic            tick;

    assign tick = (cnt == IV_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
            row  <= '0;
        end else begin
            cnt  <= tick ? '0 : cnt + 1'b1;
            pend <= tick | (pend & ~ack);
            if (ack) begin
                row <= row + 1'b1;
            end
        end
    end

    // R6: a slot always leaves a pending refresh behind it
    p_tick_sets_pend_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> pend);

    // R6: taking the refresh clears the request unless a new slot coincides
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick) |=> !pend);

    // R7: row counter moves only when a refresh is taken
    p_row_steps_r7: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(row));

endmodule

// File: rtl/mdc_access_seq.sv
module mdc_access_seq
    import mdc_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int DATA_W  = 8,
    parameter int MA_W    = 4,
    parameter int T_RCD   = 2,
    parameter int CAS_LAT = 2,
    parameter int T_PRE   = 2,
    parameter int T_REF   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    input  logic                    ref_pend,
    input  logic [ROW_W-1:0]        ref_row,
    output logic                    ref_ack,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic                    busy,
    output logic                    refreshing,
    output logic [MA_W-1:0]         dram_addr,
    output strobe_t                 strobe,
    output logic [DATA_W-1:0]       dq_out,
    output logic                    dq_oe,
    input  logic [DATA_W-1:0]       dq_in
);
    localparam int CNT_W = $clog2(max4(T_RCD, CAS_LAT, T_PRE, T_REF) + 1);

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } access_t;

    seq_state_e       state;
    access_t          acc;
    logic [CNT_W-1:0] cnt;
    int               lim;
    logic             last;

    always_comb begin
        case (state)
            ST_ROW:  lim = T_RCD;
            ST_COL:  lim = CAS_LAT;
            ST_PRE:  lim = T_PRE;
            ST_REF:  lim = T_REF;
            default: lim = 1;
        endcase
        last = (int'(cnt) == lim - 1);
    end

    assign ref_ack    = (state == ST_IDLE) && ref_pend;
    assign req_ready  = (state == ST_IDLE) && !ref_pend;
    assign busy       = (state != ST_IDLE);
    assign refreshing = (state == ST_REF);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            acc       <= '0;
            cnt       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (ref_pend) begin
                        acc.row <= ref_row;
                        acc.wr  <= 1'b0;
                        state   <= ST_REF;
                    end else if (req_valid) begin
                        acc.wr    <= req_write;
                        acc.row   <= req_addr[ROW_W+COL_W-1:COL_W];
                        acc.col   <= req_addr[COL_W-1:0];
                        acc.wdata <= req_wdata;
                        state     <= ST_ROW;
                    end
                end
                ST_ROW: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) state <= ST_COL;
                end
                ST_COL: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) begin
                        if (!acc.wr) begin
                            rsp_rdata <= dq_in;
                            rsp_valid <= 1'b1;
                        end
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) state <= ST_IDLE;
                end
                ST_REF: begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) state <= ST_PRE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe    = STROBE_IDLE;
        dram_addr = '0;
        dq_out    = acc.wdata;
        dq_oe     = 1'b0;
        case (state)
            ST_ROW, ST_REF: begin
                strobe.ras_n           = 1'b0;
                dram_addr[ROW_W-1:0]   = acc.row;
            end
            ST_COL: begin
                strobe.ras_n           = 1'b0;
                strobe.cas_n           = 1'b0;
                strobe.we_n            = !acc.wr;
                strobe.oe_n            = acc.wr;
                dq_oe                  = acc.wr;
                dram_addr[COL_W-1:0]   = acc.col;
            end
            default: ;
        endcase
    end

    // R3: column strobe only inside a row strobe
    p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (rst)
        !strobe.cas_n |-> !strobe.ras_n);

    // R2: latched row does not move during the column phase
    p_row_held_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COL) |-> $stable(acc.row));

    // R4: write and output enables never both active
    p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!strobe.we_n && !strobe.oe_n));

    // R7: refresh keeps column strobe and write enable inactive
    p_ref_ras_only_r7: assert property (@(posedge clk) disable iff (rst)
        refreshing |-> (strobe.cas_n && strobe.we_n && !strobe.ras_n));

    // R8: no host acceptance while refresh is owed
    p_ref_blocks_host_r8: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    // R5: a response follows only the column phase of a read
    p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(state) == ST_COL && !acc.wr));

    // R9: ready and busy are mutually exclusive
    p_ready_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !busy);

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
    import mdc_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int T_RCD     = 2,
    parameter int CAS_LAT   = 2,
    parameter int T_PRE     = 2,
    parameter int T_REF     = 3,
    parameter int CLK_NS    = 4,
    parameter int RETAIN_NS = 64000000,
    localparam int ADDR_W   = ROW_W + COL_W,
    localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              refreshing,
    output logic [MA_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int ROWS     = 1 << ROW_W;
    localparam int INTERVAL = refresh_interval(RETAIN_NS, CLK_NS, ROWS);

    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;
    strobe_t          strobe;

    mdc_refresh_timer #(
        .INTERVAL (INTERVAL),
        .ROW_W    (ROW_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .ack  (ref_ack),
        .pend (ref_pend),
        .row  (ref_row)
    );

    mdc_access_seq #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .DATA_W  (DATA_W),
        .MA_W    (MA_W),
        .T_RCD   (T_RCD),
        .CAS_LAT (CAS_LAT),
        .T_PRE   (T_PRE),
        .T_REF   (T_REF)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .ref_pend   (ref_pend),
        .ref_row    (ref_row),
        .ref_ack    (ref_ack),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .busy       (busy),
        .refreshing (refreshing),
        .dram_addr  (dram_addr),
        .strobe     (strobe),
        .dq_out     (dram_dq_out),
        .dq_oe      (dram_dq_oe),
        .dq_in      (dram_dq_in)
    );

    assign dram_ras_n = strobe.ras_n;
    assign dram_cas_n = strobe.cas_n;
    assign dram_we_n  = strobe.we_n;
    assign dram_oe_n  = strobe.oe_n;

    // R1: strobes idle in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !busy));

endmodule

// File: tb/dram_refresh_ctl_bench.sv
module dram_refresh_ctl_bench;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int T_RCD = 2, CAS_LAT = 2, T_PRE = 2, T_REF = 3;
    localparam int CLK_NS = 4, RETAIN_NS = 6400;
    localparam int EXP_IV = RETAIN_NS / (CLK_NS * (1 << ROW_W));   // 100
    localparam int SLACK  = T_RCD + CAS_LAT + T_PRE + 2;
    localparam int WORDS  = 1 << (ROW_W + COL_W);

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [7:0] req_addr = 0, req_wdata = 0;
    logic req_ready, rsp_valid, busy, refreshing;
    logic [7:0] rsp_rdata, dq_out, dq_in;
    logic [3:0] dram_addr;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;

    always #2 clk = ~clk;

    dram_refresh_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .CAS_LAT(CAS_LAT), .T_PRE(T_PRE), .T_REF(T_REF), .CLK_NS(CLK_NS),
        .RETAIN_NS(RETAIN_NS)) u_dram_refresh_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .refreshing(refreshing),
        .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural DRAM array
    logic [7:0] mem [WORDS];
    logic [3:0] row_l = 0;
    logic       ras_prev = 1;
    initial for (int i = 0; i < WORDS; i++) mem[i] = 8'h00;
    assign dq_in = (!cas_n && !oe_n) ? mem[{row_l, dram_addr}] : 8'h00;
    always @(negedge clk) begin
        if (!ras_n && ras_prev) row_l = dram_addr;
        if (!cas_n && !we_n && dq_oe) mem[{row_l, dram_addr}] = dq_out;
        ras_prev = ras_n;
    end

    // access bookkeeping shared with the monitor
    int  acc_cyc = -100;
    bit  in_flight = 0, cur_wr = 0, is_ref = 0, rd_out = 0;
    logic [7:0] cur_addr = 0, cur_data = 0;
    int  ras_fall = 0, ras_rise = -100, cas_fall = 0, last_ref = -1, ref_seen = 0;
    int  exp_ref_row = 0;
    bit  cas_in_ref = 0;
    logic m_ras = 1, m_cas = 1;

    always @(negedge clk) if (!rst && !done) begin
        if (!ras_n && m_ras) begin
            chk(cyc - ras_rise >= T_PRE, "R3 precharge gap", cyc - ras_rise, T_PRE);
            ras_fall = cyc;
            if (in_flight) begin
                is_ref = 0;
                in_flight = 0;
                chk(cyc == acc_cyc, "R2 RAS one cycle after accept", cyc, acc_cyc);
                chk(dram_addr == cur_addr[7:4], "R2 row bits", dram_addr, cur_addr[7:4]);
                chk(busy, "R9 busy during access", busy, 1);
            end else begin
                is_ref = 1;
                cas_in_ref = 0;
                chk(refreshing, "R9 refreshing flag", refreshing, 1);
                chk(dram_addr == 4'(exp_ref_row), "R7 refresh row", dram_addr, exp_ref_row);
                exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
                if (last_ref >= 0)
                    chk((cyc - last_ref >= EXP_IV - SLACK) && (cyc - last_ref <= EXP_IV + SLACK),
                        "R6 refresh spacing", cyc - last_ref, EXP_IV);
                last_ref = cyc;
                ref_seen++;
            end
        end
        if (!ras_n && is_ref && (!cas_n || !we_n || !oe_n)) cas_in_ref = 1;
        if (ras_n && !m_ras) begin
            ras_rise = cyc;
            if (is_ref) begin
                chk(cyc - ras_fall == T_REF, "R7 refresh RAS width", cyc - ras_fall, T_REF);
                chk(!cas_in_ref, "R7 CAS/WE/OE high in refresh", cas_in_ref, 0);
            end
        end
        if (!cas_n && m_cas) begin
            cas_fall = cyc;
            chk(cyc - ras_fall == T_RCD, "R2 RAS-to-CAS", cyc - ras_fall, T_RCD);
            chk(dram_addr == cur_addr[3:0], "R2 column bits", dram_addr, cur_addr[3:0]);
            chk(we_n == !cur_wr && oe_n == cur_wr && dq_oe == cur_wr, "R4 enables",
                {we_n, oe_n, dq_oe}, {!cur_wr, cur_wr, cur_wr});
            if (cur_wr) chk(dq_out == cur_data, "R4 write data", dq_out, cur_data);
        end
        if (cas_n && !m_cas) begin
            chk(cyc - cas_fall == CAS_LAT, "R3 CAS width", cyc - cas_fall, CAS_LAT);
            chk(ras_n, "R3 RAS rises with CAS", ras_n, 1);
        end
        if (rsp_valid) begin
            chk(rd_out, "R5 rsp only for read", rd_out, 1);
            chk(cyc - acc_cyc == T_RCD + CAS_LAT, "R5 read latency", cyc - acc_cyc, T_RCD + CAS_LAT);
            rd_out = 0;
        end
        m_ras = ras_n;
        m_cas = cas_n;
    end

    task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc + 1;
        cur_wr = wr; cur_addr = a; cur_data = d; in_flight = 1; rd_out = !wr;
        @(negedge clk);
        req_valid = 0;
        if (!wr) begin
            int waited = 0;
            while (!rsp_valid && waited < 40) begin @(negedge clk); waited++; end
            chk(rsp_valid && rsp_rdata == exp_rd, tag, rsp_rdata, exp_rd);
            @(negedge clk);
            chk(!rsp_valid, "R5 single-cycle pulse", rsp_valid, 0);
        end
    endtask

    function automatic logic [7:0] pat_a(input int a); return 8'((a * 37 + 11) & 255); endfunction
    function automatic logic [7:0] pat_b(input int a); return 8'(a) ^ 8'hA5; endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n && !dq_oe, "R1 strobes in reset",
            {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n && !dq_oe, "R1 strobes after reset",
            {ras_n, cas_n, we_n, oe_n, dq_oe}, 5'b11110);
        chk(!busy && !refreshing && !rsp_valid && req_ready, "R1 status after reset",
            {busy, refreshing, rsp_valid, req_ready}, 4'b0001);

        // sweep 1: ascending, multiplier pattern
        for (int a = 0; a < WORDS; a++) access(1, 8'(a), pat_a(a), 0, "R4 write");
        for (int a = 0; a < WORDS; a++) access(0, 8'(a), 0, pat_a(a), "R10 readback pattern A");
        // sweep 2: descending, xor pattern
        for (int a = WORDS - 1; a >= 0; a--) access(1, 8'(a), pat_b(a), 0, "R4 write");
        for (int a = 0; a < WORDS; a++) access(0, 8'(a), 0, pat_b(a), "R10 readback pattern B");

        // request offered during refresh is held off
        @(negedge clk);
        while (!refreshing) @(negedge clk);
        begin
            int rf = cyc;
            req_valid = 1; req_write = 1; req_addr = 8'h5C; req_wdata = 8'h3E;
            chk(!req_ready, "R8 ready low during refresh", req_ready, 0);
            while (!req_ready) @(negedge clk);
            acc_cyc = cyc + 1;
            cur_wr = 1; cur_addr = 8'h5C; cur_data = 8'h3E; in_flight = 1; rd_out = 0;
            chk(acc_cyc - rf >= T_REF + T_PRE, "R8 accepted after refresh+precharge",
                acc_cyc - rf, T_REF + T_PRE);
            @(negedge clk); req_valid = 0;
        end
        access(0, 8'h5C, 0, 8'h3E, "R8 held request completes");
        chk(ref_seen > (1 << ROW_W), "R7 refresh counter wrapped", ref_seen, (1 << ROW_W) + 1);

        repeat (10) @(negedge clk);
        chk(!busy && req_ready, "R9 idle after traffic", {busy, req_ready}, 2'b01);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule